// File: doc/BRIEF.md
# Two-Stage Timesliced DRAM Request Arbiter

This block decides which of three request streams may use system DRAM next. Two host-side streams compete first: a host-to-graphics stream and a general host stream. Their winner then competes with a low-priority graphics stream. The block grants one stream at a time. A grant stays with its stream until that stream's packet ends, and each packet may be several beats long.

A single mode input selects the policy. With the mode off, the host side always wins, and within the host side the host-to-graphics stream wins. With the mode on, two extra rules apply. First, the host-to-graphics stream may win no more than six packets in a row while the general host stream is waiting. Second, the final stage runs a free-running pair of 24-clock windows: in the first the host side has priority, and in the second the graphics stream has priority. In both modes an idle preferred stream lets the other stream through.

A beat transfers on a cycle where a stream's valid and grant are both high. The grant therefore acts as that stream's ready. The last input marks the final beat of a packet. A requester keeps valid high from the first beat of a packet to its last beat.

Top module: `dram_slice_arb`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, all three grants are low, the mode is off, and every counter is zero.
- R2: At most one of hg_gnt_o, hc_gnt_o and lg_gnt_o is high in any cycle. Grants change only at a rising clock edge, and are decided from the inputs sampled at that edge.
- R3: With the mode off, a boundary decision with any host-side request valid never grants the graphics stream, and a valid host-to-graphics request beats the general host request.
- R4: With the mode on, once six host-to-graphics packets have completed in a row, a valid general host request wins the next boundary decision, unless the graphics window is open and graphics is valid.
- R5: The consecutive-packet count returns to zero when the general host stream is picked, or on any cycle where hg_valid_i is low. It saturates at six.
- R6: With the mode on, a window counter runs every clock. The first 24 clocks after the mode takes effect give host priority, the next 24 give graphics priority, and the two alternate from then on.
- R7: If the stream preferred at a boundary has no valid request, the other stream is granted, and the window counter keeps running. With no valid request, no grant is issued.
- R8: Once a beat without last transfers, the grant stays with that stream until its beat with last transfers. Other streams receive no grant in between.
- R9: win_en_i is sampled only at boundary cycles, meaning cycles where no packet is being held. It takes effect for decisions from the following cycle on. Any change clears the window and packet counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| win_en_i | input | 1 | Timeslice mode enable (0 = fixed priority) |
| hg_valid_i | input | 1 | Host-to-graphics stream beat valid |
| hg_last_i | input | 1 | Host-to-graphics final beat of packet |
| hc_valid_i | input | 1 | General host stream beat valid |
| hc_last_i | input | 1 | General host final beat of packet |
| lg_valid_i | input | 1 | Low-priority graphics stream beat valid |
| lg_last_i | input | 1 | Low-priority graphics final beat of packet |
| hg_gnt_o | output | 1 | Grant / ready for host-to-graphics stream |
| hc_gnt_o | output | 1 | Grant / ready for general host stream |
| lg_gnt_o | output | 1 | Grant / ready for graphics stream |

## Verification
The hardest situations to reach from the ports are the ones where limits coincide: the six-packet cap is reached on the same boundary where the general host stream is waiting, or a window flips or the mode input changes while a multi-beat packet is still being held. The stimulus keeps chosen streams saturated with single-beat packets, so that a boundary decision occurs every cycle and the cap and window edges fall on boundaries. It also runs long random multi-beat traffic while toggling win_en_i at a period unrelated to the window length, so that mode changes arrive in the middle of packets. A behavioural reference model in the bench predicts the owner for every cycle.

// File: rtl/dram_slice_arb_pkg.sv
package dram_slice_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HG   = 2'd1,
    OWN_HC   = 2'd2,
    OWN_LG   = 2'd3
  } owner_e;
endpackage

// File: rtl/dram_slice_pkt_cap.sv
module dram_slice_pkt_cap #(
  parameter int unsigned PKT_CAP = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  input  logic clr_i,
  input  logic hg_done_i,
  input  logic hg_idle_i,
  input  logic hc_pick_i,
  output logic cap_hit_o
);
  localparam int unsigned CW = $clog2(PKT_CAP + 1);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_ahead;

  // include the packet completing this cycle in the decision
  assign cnt_ahead = {1'b0, cnt_q} + (CW+1)'(hg_done_i);
  assign cap_hit_o = cnt_ahead >= (CW+1)'(PKT_CAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || !on_i || hc_pick_i || hg_idle_i) begin
      cnt_q <= '0;
    end else if (hg_done_i && (cnt_q < CW'(PKT_CAP))) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/dram_slice_win_timer.sv
module dram_slice_win_timer #(
  parameter int unsigned WIN_CLKS = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  input  logic clr_i,
  output logic lg_turn_o
);
  localparam int unsigned WW = (WIN_CLKS > 1) ? $clog2(WIN_CLKS) : 1;

  logic [WW-1:0] cnt_q;
  logic          lg_turn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      lg_turn_q <= 1'b0;
    end else if (clr_i || !on_i) begin
      cnt_q     <= '0;
      lg_turn_q <= 1'b0;
    end else if (cnt_q == WW'(WIN_CLKS - 1)) begin
      cnt_q     <= '0;
      lg_turn_q <= !lg_turn_q;
    end else begin
      cnt_q <= cnt_q + WW'(1);
    end
  end

  assign lg_turn_o = lg_turn_q;
endmodule

// File: rtl/dram_slice_pick.sv
module dram_slice_pick
  import dram_slice_arb_pkg::*;
(
  input  logic   hg_valid_i,
  input  logic   hc_valid_i,
  input  logic   lg_valid_i,
  input  logic   slice_on_i,
  input  logic   cap_hit_i,
  input  logic   lg_turn_i,
  output owner_e pick_o
);
  owner_e host_sel;
  logic   host_v;
  logic   lg_first;

  // stage 1: merge the two host streams
  always_comb begin
    if (hg_valid_i && !(slice_on_i && cap_hit_i && hc_valid_i)) host_sel = OWN_HG;
    else if (hc_valid_i)                                         host_sel = OWN_HC;
    else                                                          host_sel = OWN_NONE;
  end

  assign host_v   = hg_valid_i || hc_valid_i;
  assign lg_first = slice_on_i && lg_turn_i;

  // stage 2: host vs graphics, work-conserving
  always_comb begin
    if (lg_first && lg_valid_i) pick_o = OWN_LG;
    else if (host_v)            pick_o = host_sel;
    else if (lg_valid_i)        pick_o = OWN_LG;
    else                        pick_o = OWN_NONE;
  end
endmodule

// File: rtl/dram_slice_arb.sv
module dram_slice_arb
  import dram_slice_arb_pkg::*;
#(
  parameter int unsigned PKT_CAP  = 6,
  parameter int unsigned WIN_CLKS = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_en_i,
  input  logic hg_valid_i,
  input  logic hg_last_i,
  input  logic hc_valid_i,
  input  logic hc_last_i,
  input  logic lg_valid_i,
  input  logic lg_last_i,
  output logic hg_gnt_o,
  output logic hc_gnt_o,
  output logic lg_gnt_o
);
  owner_e owner_q, owner_d, pick_w;
  logic   in_pkt_q;
  logic   mode_q;
  logic   cur_valid, cur_last;
  logic   xfer_w, done_w, hold_w, clr_w;
  logic   cap_hit_w, lg_turn_w;

  always_comb begin
    unique case (owner_q)
      OWN_HG:  begin cur_valid = hg_valid_i; cur_last = hg_last_i; end
      OWN_HC:  begin cur_valid = hc_valid_i; cur_last = hc_last_i; end
      OWN_LG:  begin cur_valid = lg_valid_i; cur_last = lg_last_i; end
      default: begin cur_valid = 1'b0;       cur_last = 1'b0;      end
    endcase
  end

  assign xfer_w = cur_valid;
  assign done_w = xfer_w && cur_last;
  // keep the owner while a packet is open
  assign hold_w = (xfer_w && !cur_last) || (in_pkt_q && !done_w);
  assign clr_w  = !hold_w && (win_en_i != mode_q);

  dram_slice_pkt_cap #(.PKT_CAP(PKT_CAP)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .on_i      (mode_q),
    .clr_i     (clr_w),
    .hg_done_i (done_w && (owner_q == OWN_HG)),
    .hg_idle_i (!hg_valid_i),
    .hc_pick_i (!hold_w && (pick_w == OWN_HC)),
    .cap_hit_o (cap_hit_w)
  );

  dram_slice_win_timer #(.WIN_CLKS(WIN_CLKS)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .on_i      (mode_q),
    .clr_i     (clr_w),
    .lg_turn_o (lg_turn_w)
  );

  dram_slice_pick u_pick (
    .hg_valid_i (hg_valid_i),
    .hc_valid_i (hc_valid_i),
    .lg_valid_i (lg_valid_i),
    .slice_on_i (mode_q),
    .cap_hit_i  (cap_hit_w),
    .lg_turn_i  (lg_turn_w),
    .pick_o     (pick_w)
  );

  assign owner_d = hold_w ? owner_q : pick_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q  <= OWN_NONE;
      in_pkt_q <= 1'b0;
      mode_q   <= 1'b0;
      hg_gnt_o <= 1'b0;
      hc_gnt_o <= 1'b0;
      lg_gnt_o <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      in_pkt_q <= hold_w;
      if (!hold_w) mode_q <= win_en_i;
      hg_gnt_o <= (owner_d == OWN_HG);
      hc_gnt_o <= (owner_d == OWN_HC);
      lg_gnt_o <= (owner_d == OWN_LG);
    end
  end
endmodule

// File: rtl/dram_slice_arb_chk.sv
module dram_slice_arb_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hg_valid_i,
  input logic hg_last_i,
  input logic hc_valid_i,
  input logic hc_last_i,
  input logic lg_valid_i,
  input logic lg_last_i,
  input logic hg_gnt_o,
  input logic hc_gnt_o,
  input logic lg_gnt_o,
  input logic mode_q,
  input logic hold_w,
  input logic cap_hit_w,
  input logic lg_turn_w
);
  // R2: one owner at most
  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hg_gnt_o, hc_gnt_o, lg_gnt_o}));

  // R8: no cut mid-packet
  a_r8_hold_hg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hg_gnt_o && hg_valid_i && !hg_last_i) |=> hg_gnt_o);
  a_r8_hold_hc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hc_gnt_o && hc_valid_i && !hc_last_i) |=> hc_gnt_o);
  a_r8_hold_lg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lg_gnt_o && lg_valid_i && !lg_last_i) |=> lg_gnt_o);

  // R3: fixed priority
  a_r3_host_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && !hold_w && (hg_valid_i || hc_valid_i)) |=> !lg_gnt_o);
  a_r3_hg_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && !hold_w && hg_valid_i) |=> hg_gnt_o);

  // R4: cap hands over to the general host stream
  a_r4_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && !hold_w && cap_hit_w && hc_valid_i && !(lg_turn_w && lg_valid_i))
    |=> hc_gnt_o);

  // R7: idle host lets graphics through
  a_r7_idle_host: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_w && lg_valid_i && !hg_valid_i && !hc_valid_i) |=> lg_gnt_o);

  // R9: mode moves only after a boundary
  a_r9_mode_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> !$past(hold_w));
endmodule

bind dram_slice_arb dram_slice_arb_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hg_valid_i (hg_valid_i),
  .hg_last_i  (hg_last_i),
  .hc_valid_i (hc_valid_i),
  .hc_last_i  (hc_last_i),
  .lg_valid_i (lg_valid_i),
  .lg_last_i  (lg_last_i),
  .hg_gnt_o   (hg_gnt_o),
  .hc_gnt_o   (hc_gnt_o),
  .lg_gnt_o   (lg_gnt_o),
  .mode_q     (mode_q),
  .hold_w     (hold_w),
  .cap_hit_w  (cap_hit_w),
  .lg_turn_w  (lg_turn_w)
);

// File: tb/dram_slice_arb_bench.sv
`timescale 1ns/1ps
module dram_slice_arb_bench;
  localparam int CAP = 6;
  localparam int WIN = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic v [1:3];
  logic l [1:3];
  logic g_hg, g_hc, g_lg;

  int n_run = 0, n_fail = 0;
  string tag = "R1";

  always #10 clk = !clk;

  dram_slice_arb u_dram_slice_arb (
    .clk_i(clk), .rst_ni(rst_n), .win_en_i(en),
    .hg_valid_i(v[1]), .hg_last_i(l[1]),
    .hc_valid_i(v[2]), .hc_last_i(l[2]),
    .lg_valid_i(v[3]), .lg_last_i(l[3]),
    .hg_gnt_o(g_hg), .hc_gnt_o(g_hc), .lg_gnt_o(g_lg)
  );

  // behavioural reference model
  int m_own, m_pc, m_wc, m_ph, m_new;
  bit m_inpkt, m_mode, m_dn, m_hl, m_hit, m_clr;
  bit m_x [1:3];
  bit m_xl [1:3];
  int order [0:2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_own = 0; m_pc = 0; m_wc = 0; m_ph = 0; m_inpkt = 0; m_mode = 0;
      for (int s = 1; s <= 3; s++) begin m_x[s] = 0; m_xl[s] = 0; end
    end else begin
      for (int s = 1; s <= 3; s++) begin m_x[s] = 0; m_xl[s] = 0; end
      if (m_own != 0 && v[m_own]) begin m_x[m_own] = 1; m_xl[m_own] = l[m_own]; end
      m_dn = (m_own != 0) && v[m_own] && l[m_own];
      m_hl = ((m_own != 0) && v[m_own] && !l[m_own]) || (m_inpkt && !m_dn);
      m_hit = (m_pc + ((m_own == 1 && m_dn) ? 1 : 0)) >= CAP;
      if (m_hl) m_new = m_own;
      else begin
        int a, b;
        a = (m_mode && m_hit) ? 2 : 1;
        b = (a == 2) ? 1 : 2;
        if (m_mode && m_ph == 1) begin order[0] = 3; order[1] = a; order[2] = b; end
        else begin order[0] = a; order[1] = b; order[2] = 3; end
        m_new = 0;
        for (int k = 2; k >= 0; k--) if (v[order[k]]) m_new = order[k];
      end
      m_clr = !m_hl && (en != m_mode);
      if (m_clr || !m_mode) m_pc = 0;
      else if ((!m_hl && m_new == 2) || !v[1]) m_pc = 0;
      else if (m_own == 1 && m_dn && m_pc < CAP) m_pc = m_pc + 1;
      if (m_clr || !m_mode) begin m_wc = 0; m_ph = 0; end
      else if (m_wc == WIN - 1) begin m_wc = 0; m_ph = 1 - m_ph; end
      else m_wc = m_wc + 1;
      if (!m_hl) m_mode = en;
      m_inpkt = m_hl;
      m_own = m_new;
    end
  end

  // stimulus and statistics
  int rem [1:3];
  int prob [1:3];
  int mlen [1:3];
  int cnt_x [1:3];
  int cnt_p [1:3];
  int run, max_run, n_interleave;
  bit open [1:3];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_stats();
    for (int s = 1; s <= 3; s++) begin cnt_x[s] = 0; cnt_p[s] = 0; end
    run = 0; max_run = 0; n_interleave = 0;
  endtask

  task automatic step();
    int gc;
    @(posedge clk);
    @(negedge clk);
    gc = g_hg ? 1 : g_hc ? 2 : g_lg ? 3 : 0;
    check((32'(g_hg) + 32'(g_hc) + 32'(g_lg)) <= 1, "R2", "grants not one-hot",
          32'(g_hg) + 32'(g_hc) + 32'(g_lg), 1);
    check(gc == m_own, tag, "owner vs model", gc, m_own);
    for (int s = 1; s <= 3; s++) begin
      if (m_x[s]) begin
        cnt_x[s]++;
        for (int t = 1; t <= 3; t++) if (t != s && open[t]) n_interleave++;
        open[s] = !m_xl[s];
        if (m_xl[s]) cnt_p[s]++;
        if (m_xl[s] && s == 1) begin run++; if (run > max_run) max_run = run; end
        if (s == 2) run = 0;
      end
      if (m_x[s]) rem[s]--;
      if (rem[s] == 0 && $urandom_range(99) < prob[s])
        rem[s] = 1 + $urandom_range(mlen[s] - 1);
      v[s] = rem[s] > 0;
      l[s] = rem[s] == 1;
    end
  endtask

  task automatic setup(input string t, input bit e, input int p1, input int p2, input int p3,
                       input int l1, input int l2, input int l3);
    tag = t; en = e;
    prob[1] = p1; prob[2] = p2; prob[3] = p3;
    mlen[1] = l1; mlen[2] = l2; mlen[3] = l3;
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    for (int s = 1; s <= 3; s++) begin
      v[s] = 0; l[s] = 0; rem[s] = 0; prob[s] = 0; mlen[s] = 1; open[s] = 0;
    end
    clear_stats();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: grants low in reset
    check(!g_hg && !g_hc && !g_lg, "R1", "grants in reset", 32'(g_hg | g_hc | g_lg), 0);
    rst_n = 1'b1;
    step();
    check(!g_hg && !g_hc && !g_lg, "R1", "grants after reset", 32'(g_hg | g_hc | g_lg), 0);

    // R3: fixed priority under saturation
    setup("R3", 1'b0, 100, 100, 100, 3, 2, 2);
    run_cycles(20); clear_stats(); run_cycles(300);
    check(cnt_x[3] == 0, "R3", "graphics beats in fixed mode", cnt_x[3], 0);
    check(cnt_x[2] == 0, "R3", "general host beats behind hg", cnt_x[2], 0);
    check(cnt_x[1] > 250, "R3", "hg beats served", cnt_x[1], 300);

    // R4: six-packet cap with general host waiting
    setup("R4", 1'b1, 100, 100, 0, 1, 1, 1);
    run_cycles(40); clear_stats(); run_cycles(300);
    check(max_run == CAP, "R4", "longest hg packet run", max_run, CAP);
    check(cnt_p[2] > 30, "R4", "general host packets", cnt_p[2], 40);

    // R5: idle cycles on hg clear the run
    setup("R5", 1'b1, 60, 100, 0, 1, 1, 1);
    run_cycles(40); clear_stats(); run_cycles(400);
    check(max_run <= CAP, "R5", "hg run bounded", max_run, CAP);

    // R6: alternating windows
    setup("R6", 1'b1, 100, 0, 100, 1, 1, 1);
    run_cycles(48); clear_stats(); run_cycles(480);
    check(cnt_x[3] >= 200 && cnt_x[3] <= 280, "R6", "graphics share of 480", cnt_x[3], 240);
    check(cnt_x[1] >= 200 && cnt_x[1] <= 280, "R6", "host share of 480", cnt_x[1], 240);

    // R7: preferred stream idle
    setup("R7", 1'b1, 0, 0, 100, 1, 1, 1);
    run_cycles(20); clear_stats(); run_cycles(200);
    check(cnt_x[3] >= 198, "R7", "graphics served through host windows", cnt_x[3], 200);
    setup("R7", 1'b1, 0, 0, 0, 1, 1, 1);
    run_cycles(10);
    check(!g_hg && !g_hc && !g_lg, "R7", "no grant without request", 32'(g_hg | g_hc | g_lg), 0);

    // R8: multi-beat random traffic, no interleave
    setup("R8", 1'b1, 80, 80, 80, 4, 4, 4);
    clear_stats(); run_cycles(2000);
    check(n_interleave == 0, "R8", "interleaved beats", n_interleave, 0);

    // R9: mode toggles mid-packet
    for (int k = 0; k < 60; k++) begin
      setup("R9", k[0], 70, 70, 70, 4, 3, 5);
      run_cycles(37);
    end
    check(n_interleave == 0, "R9", "interleaved beats across mode changes", n_interleave, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_fail++;
    n_run++;
    $display("FAIL watchdog expired in %s actual=1 expected=0", tag);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule